// File: doc/BRIEF.md
# Synchronisable Bridge PWM Generator

This block drives the two halves of a bridge-tied load with complementary pulse-width modulated signals. The duty comes from a signed command. It sets how far the positive output's high time moves above or below half a switching period. A zero command gives a square wave on both halves and no net differential drive.

A strap input picks the timing source. In master mode a free-running counter of `MASTER_PERIOD` clocks defines the switching period. The block also drives a shared sync line that toggles at twice the switching rate, so other instances can follow it. In slave mode the sync line is an input. Every second rising edge of it starts a new switching period, so a follower switches at half the incoming sync rate and stays phase-locked to the master. The default of 320 clocks gives 312.5 kHz from a 100 MHz clock. That is inside the usable 250 to 400 kHz switching band; any other clock and period pair must also land inside that band.

An external controller can request mute or a high-impedance bridge at any time. In slave mode a watchdog releases the bridge if the sync clock stops.

Top module: `bridge_pwm_top`

## Requirements
- R1: In master mode (`slave_sel`=0) `sync_oe` is 1. `sync_out` has a period of `MASTER_PERIOD`/2 clocks and is high for the first `MASTER_PERIOD`/4 clocks of each of its periods. Its rising edges fall at the start and at the middle of every switching period.
- R2: In slave mode (`slave_sel`=1) `sync_oe` is 0. Both bridge enables stay 0 until the first `sync_in` rising edge. From then on, each switching period lasts two `sync_in` periods, whatever the nominal period.
- R3: With a zero command, `out_p` is high for the first H = `MASTER_PERIOD`/2 clocks of each period. `out_n` is its complement, so each is high for H clocks.
- R4: A command d (two's complement) makes `out_p` high for H+d clocks from the start of the period. `out_n` is high for the rest of the period, which is H−d clocks in master mode.
- R5: The command is clamped to ±(H−`MIN_PULSE`), so neither output pulse is shorter than `MIN_PULSE` clocks. The extreme values +max and −min produce exactly that limit.
- R6: A new command takes effect only from the next period start. A change in mid-period leaves the running pulse unchanged.
- R7: While `mute_req` is 1, both outputs run at 50% duty (H clocks high per nominal period), whatever the command.
- R8: While `hiz_req` is 1, `out_p_oe` and `out_n_oe` are 0 and `out_p`/`out_n` are 0. This request overrides mute.
- R9: In slave mode, `SYNC_TIMEOUT` clocks without a `sync_in` rising edge set `sync_lost` and drop both enables. The next rising edge clears `sync_lost` and restarts switching.
- R10: After reset in master mode, both enables are 1, `sync_lost` is 0 and the command register holds zero duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_sel | input | 1 | Strap: 0 master timebase, 1 follow external sync |
| duty_cmd | input | DUTY_W | Signed duty offset in clocks |
| mute_req | input | 1 | Force 50% duty on both outputs |
| hiz_req | input | 1 | Release both bridge outputs |
| sync_in | input | 1 | Sync line as received (used in slave mode) |
| sync_out | output | 1 | Sync line driven value (master mode) |
| sync_oe | output | 1 | Sync line driver enable |
| out_p | output | 1 | Positive bridge drive value |
| out_n | output | 1 | Negative bridge drive value |
| out_p_oe | output | 1 | Positive bridge driver enable |
| out_n_oe | output | 1 | Negative bridge driver enable |
| sync_lost | output | 1 | Slave sync watchdog expired |

## Verification
The duty path is tried with zero, small positive and small negative commands, which show that the offset is applied and that the two halves stay complementary. It is also tried with the exact clamp value and with both extreme codes, which show that clamping happens at the limit and not before it. The same command is measured under a slave sync that matches the nominal period and under a slower one. The slower sync separates a period taken from the sync line from one taken from the internal counter. A command changed mid-period, mute over a large command, and high impedance over mute each show which source wins.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;

    typedef enum logic {
        MODE_MASTER = 1'b0,
        MODE_SLAVE  = 1'b1
    } bpwm_mode_e;

    // Positive-half high time for a signed offset, clamped so both halves
    // keep at least min_pulse clocks.
    function automatic int bpwm_clamp_width(int cmd, int half, int min_pulse);
        int lim;
        int c;
        lim = half - min_pulse;
        c   = cmd;
        if (c > lim)
            c = lim;
        else if (c < -lim)
            c = -lim;
        return half + c;
    endfunction

endpackage

// File: rtl/bpwm_sync_rx.sv
module bpwm_sync_rx #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = sync_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.chain[STAGES-1] & ~st_q.prev;

    // R2
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/bpwm_timebase.sv
module bpwm_timebase
    import bpwm_pkg::*;
#(
    parameter int MASTER_PERIOD = 320,
    parameter int SYNC_TIMEOUT  = 1024,
    localparam int CW  = $clog2(MASTER_PERIOD + 1),
    localparam int WDW = $clog2(SYNC_TIMEOUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bpwm_mode_e    mode,
    input  logic          sync_rise,
    output logic [CW-1:0] cnt,
    output logic          boundary,
    output logic          locked,
    output logic          lost,
    output logic          sync_drive
);
    localparam int HALF    = MASTER_PERIOD / 2;
    localparam int QUARTER = MASTER_PERIOD / 4;
    localparam logic [CW-1:0] LAST    = CW'(MASTER_PERIOD - 1);
    localparam logic [CW-1:0] CMAX    = '1;
    localparam logic [CW-1:0] HALF_C  = CW'(HALF);
    localparam logic [CW-1:0] QUART_C = CW'(QUARTER);
    localparam logic [WDW-1:0] WD_END = WDW'(SYNC_TIMEOUT - 1);

    typedef struct packed {
        logic [CW-1:0]  cnt;
        logic           phase;
        logic [WDW-1:0] wd;
        logic           locked;
        logic           lost;
    } tb_st_t;

    localparam tb_st_t TB_RESET = '{cnt: '0, phase: 1'b1, wd: '0, locked: 1'b0, lost: 1'b0};

    tb_st_t st_d, st_q;
    logic   is_master;
    logic   bnd;
    logic [CW-1:0] half_pos;

    assign is_master = (mode == MODE_MASTER);

    always_comb begin
        st_d = st_q;
        bnd  = 1'b0;
        if (is_master) begin
            bnd         = (st_q.cnt == LAST);
            st_d.cnt    = bnd ? '0 : st_q.cnt + 1'b1;
            st_d.phase  = 1'b1;
            st_d.wd     = '0;
            st_d.locked = 1'b0;
            st_d.lost   = 1'b0;
        end else begin
            bnd = sync_rise & st_q.phase;
            if (bnd)
                st_d.cnt = '0;
            else if (st_q.cnt != CMAX)
                st_d.cnt = st_q.cnt + 1'b1;
            if (sync_rise) begin
                st_d.phase = ~st_q.phase;
                st_d.wd    = '0;
                st_d.lost  = 1'b0;
                if (bnd) st_d.locked = 1'b1;
            end else if (st_q.wd == WD_END) begin
                st_d.lost   = 1'b1;
                st_d.locked = 1'b0;
                st_d.phase  = 1'b1;
            end else begin
                st_d.wd = st_q.wd + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TB_RESET;
        else        st_q <= st_d;
    end

    assign half_pos   = (st_q.cnt >= HALF_C) ? st_q.cnt - HALF_C : st_q.cnt;
    assign sync_drive = is_master && (half_pos < QUART_C);
    assign cnt        = st_q.cnt;
    assign boundary   = bnd;
    assign locked     = st_q.locked;
    assign lost       = st_q.lost;

    // R1
    sync_edge_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && $rose(sync_drive)) |-> (st_q.cnt == '0 || st_q.cnt == HALF_C));

    // R9
    lost_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lost |-> !st_q.locked);

    // R9
    edge_clears_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && sync_rise) |=> !st_q.lost);

endmodule

// File: rtl/bpwm_shaper.sv
module bpwm_shaper
    import bpwm_pkg::*;
#(
    parameter int MASTER_PERIOD = 320,
    parameter int DUTY_W        = 10,
    parameter int MIN_PULSE     = 8,
    localparam int CW = $clog2(MASTER_PERIOD + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DUTY_W-1:0] duty_cmd,
    input  logic                     boundary,
    input  logic [CW-1:0]            cnt,
    input  logic                     active,
    input  logic                     mute_req,
    input  logic                     hiz_req,
    output logic                     drv_p,
    output logic                     drv_n,
    output logic                     drv_oe
);
    localparam int HALF = MASTER_PERIOD / 2;
    localparam logic [CW-1:0] HALF_C = CW'(HALF);
    localparam logic [CW-1:0] MIN_C  = CW'(MIN_PULSE);
    localparam logic [CW-1:0] MAX_C  = CW'(MASTER_PERIOD - MIN_PULSE);

    typedef struct packed {
        logic [CW-1:0] width;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic [CW-1:0] eff_width;
    logic          raw_p;
    logic          en;

    always_comb begin
        st_d = st_q;
        if (boundary)
            st_d.width = CW'(bpwm_clamp_width(int'(duty_cmd), HALF, MIN_PULSE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.width <= HALF_C;
        else        st_q <= st_d;
    end

    assign eff_width = mute_req ? HALF_C : st_q.width;
    assign raw_p     = (cnt < eff_width);
    assign en        = active && !hiz_req;
    assign drv_p     = en & raw_p;
    assign drv_n     = en & ~raw_p;
    assign drv_oe    = en;

    // R6
    width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(st_q.width));

    // R5
    width_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.width >= MIN_C) && (st_q.width <= MAX_C));

endmodule

// File: rtl/bridge_pwm_top.sv
module bridge_pwm_top
    import bpwm_pkg::*;
#(
    parameter int MASTER_PERIOD = 320,
    parameter int DUTY_W        = 10,
    parameter int MIN_PULSE     = 8,
    parameter int SYNC_TIMEOUT  = 1024,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     slave_sel,
    input  logic signed [DUTY_W-1:0] duty_cmd,
    input  logic                     mute_req,
    input  logic                     hiz_req,
    input  logic                     sync_in,
    output logic                     sync_out,
    output logic                     sync_oe,
    output logic                     out_p,
    output logic                     out_n,
    output logic                     out_p_oe,
    output logic                     out_n_oe,
    output logic                     sync_lost
);
    localparam int CW = $clog2(MASTER_PERIOD + 1);

    bpwm_mode_e    mode;
    logic          rise;
    logic [CW-1:0] cnt;
    logic          boundary;
    logic          locked;
    logic          lost;
    logic          sync_drive;
    logic          active;
    logic          drv_oe;

    assign mode = slave_sel ? MODE_SLAVE : MODE_MASTER;

    bpwm_sync_rx #(.STAGES(SYNC_STAGES)) rx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .rise    (rise)
    );

    bpwm_timebase #(
        .MASTER_PERIOD (MASTER_PERIOD),
        .SYNC_TIMEOUT  (SYNC_TIMEOUT)
    ) tb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .sync_rise  (rise),
        .cnt        (cnt),
        .boundary   (boundary),
        .locked     (locked),
        .lost       (lost),
        .sync_drive (sync_drive)
    );

    assign active = (mode == MODE_MASTER) || locked;

    bpwm_shaper #(
        .MASTER_PERIOD (MASTER_PERIOD),
        .DUTY_W        (DUTY_W),
        .MIN_PULSE     (MIN_PULSE)
    ) sh_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .duty_cmd (duty_cmd),
        .boundary (boundary),
        .cnt      (cnt),
        .active   (active),
        .mute_req (mute_req),
        .hiz_req  (hiz_req),
        .drv_p    (out_p),
        .drv_n    (out_n),
        .drv_oe   (drv_oe)
    );

    assign out_p_oe  = drv_oe;
    assign out_n_oe  = drv_oe;
    assign sync_out  = sync_drive;
    assign sync_oe   = (mode == MODE_MASTER);
    assign sync_lost = lost;

    // R8
    hiz_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hiz_req |-> (!out_p_oe && !out_n_oe && !out_p && !out_n));

    // R2
    slave_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave_sel |-> (!sync_oe && !sync_out));

    // R3
    complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_p_oe |-> (out_p != out_n));

endmodule

// File: tb/bridge_pwm_top_tb.sv
module bridge_pwm_top_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  PER  = 32;
    localparam int  H    = PER / 2;
    localparam int  MINP = 3;
    localparam int  TMO  = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slave_sel = 1'b0;
    logic signed [7:0] duty_cmd = '0;
    logic mute_req = 1'b0;
    logic hiz_req = 1'b0;
    logic sync_in;
    logic sync_out, sync_oe, out_p, out_n, out_p_oe, out_n_oe, sync_lost;

    int sync_half = 0;
    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    typedef struct { int req; int val; } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    bridge_pwm_top #(
        .MASTER_PERIOD (PER),
        .DUTY_W        (8),
        .MIN_PULSE     (MINP),
        .SYNC_TIMEOUT  (TMO),
        .SYNC_STAGES   (2)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slave_sel (slave_sel),
        .duty_cmd  (duty_cmd),
        .mute_req  (mute_req),
        .hiz_req   (hiz_req),
        .sync_in   (sync_in),
        .sync_out  (sync_out),
        .sync_oe   (sync_oe),
        .out_p     (out_p),
        .out_n     (out_n),
        .out_p_oe  (out_p_oe),
        .out_n_oe  (out_n_oe),
        .sync_lost (sync_lost)
    );

    // external sync source
    initial begin
        sync_in = 1'b0;
        forever begin
            if (sync_half > 0) begin
                sync_in = 1'b1;
                repeat (sync_half) @(negedge clk);
                sync_in = 1'b0;
                repeat (sync_half) @(negedge clk);
            end else begin
                @(negedge clk);
            end
        end
    end

    // driver side: queue the expected item
    task automatic push_exp(input int req, input int val);
        exp_t e;
        e.req = req;
        e.val = val;
        exp_q.push_back(e);
    endtask

    // monitor side: pop and compare against an observed value
    task automatic observe(input int act);
        exp_t e;
        vectors++;
        if (exp_q.size() == 0) begin
            miscompares++;
            $display("FAIL R0: got %0d expected <empty queue>", act);
            return;
        end
        e = exp_q.pop_front();
        if (act != e.val) begin
            miscompares++;
            $display("FAIL R%0d: got %0d expected %0d", e.req, act, e.val);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    task automatic do_reset(input logic slave);
        rst_n = 1'b0;
        slave_sel = slave;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one full period of out_p, rising edge to rising edge, sampled at negedges
    task automatic measure(output int wp, output int wn, output int per);
        logic prev;
        int guard;
        wp = 0; wn = 0; per = 0;
        @(negedge clk);
        prev = out_p;
        guard = 0;
        forever begin
            @(negedge clk);
            guard++;
            if ((out_p && !prev) || guard > 200) break;
            prev = out_p;
        end
        guard = 0;
        forever begin
            per++;
            wp += int'(out_p);
            wn += int'(out_n);
            prev = out_p;
            @(negedge clk);
            guard++;
            if ((out_p && !prev) || guard > 200) break;
        end
    endtask

    task automatic check_duty(input int req, input int cmd, input int ewp, input int ewn, input int eper);
        int wp, wn, per;
        duty_cmd = 8'(cmd);
        measure(wp, wn, per);
        push_exp(req, ewp); push_exp(req, ewn); push_exp(req, eper);
        observe(wp); observe(wn); observe(per);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int hi, per;
        logic prev;
        do_reset(1'b0);

        // R10: reset state in master mode
        @(negedge clk);
        push_exp(10, 1); observe(int'(out_p_oe));
        push_exp(10, 1); observe(int'(out_n_oe));
        push_exp(10, 0); observe(int'(sync_lost));
        // R1: master drives the sync line
        push_exp(1, 1); observe(int'(sync_oe));

        // R3: zero command
        check_duty(3, 0, H, H, PER);
        // R4: symmetric offsets
        check_duty(4, 5, H + 5, H - 5, PER);
        check_duty(4, -5, H - 5, H + 5, PER);
        // R5: clamp limit and extremes
        check_duty(5, H - MINP, PER - MINP, MINP, PER);
        check_duty(5, 127, PER - MINP, MINP, PER);
        check_duty(5, -128, MINP, PER - MINP, PER);

        // R1: sync_out period and high time
        @(negedge clk); prev = sync_out;
        forever begin @(negedge clk); if (sync_out && !prev) break; prev = sync_out; end
        hi = 0; per = 0;
        forever begin
            per++; hi += int'(sync_out); prev = sync_out;
            @(negedge clk);
            if ((sync_out && !prev) || per > 200) break;
        end
        push_exp(1, PER / 2); observe(per);
        push_exp(1, PER / 4); observe(hi);

        // R6: mid-period change does not alter the running pulse
        check_duty(6, 0, H, H, PER);
        @(negedge clk); prev = out_p;
        forever begin @(negedge clk); if (out_p && !prev) break; prev = out_p; end
        repeat (2) @(negedge clk);
        duty_cmd = 8'sd10;
        repeat (H) @(negedge clk);
        push_exp(6, 0); observe(int'(out_p));
        check_duty(6, 10, H + 10, H - 10, PER);

        // R7: mute overrides a large command
        mute_req = 1'b1;
        check_duty(7, 127, H, H, PER);

        // R8: high impedance overrides mute
        hiz_req = 1'b1;
        @(negedge clk);
        push_exp(8, 0); observe(int'(out_p_oe));
        push_exp(8, 0); observe(int'(out_n_oe));
        push_exp(8, 0); observe(int'(out_p | out_n));
        hiz_req = 1'b0;
        mute_req = 1'b0;
        @(negedge clk);
        push_exp(8, 1); observe(int'(out_p_oe));

        // R2: slave mode, sync line is an input, bridge idle until first edge
        duty_cmd = 8'sd5;
        do_reset(1'b1);
        repeat (10) @(negedge clk);
        push_exp(2, 0); observe(int'(sync_oe));
        push_exp(2, 0); observe(int'(out_p_oe));
        sync_half = H / 2;
        repeat (3 * PER) @(negedge clk);
        push_exp(2, 1); observe(int'(out_p_oe));
        check_duty(2, 5, H + 5, H - 5, PER);
        // R2: slower sync stretches the period, pulse stays H+d
        sync_half = 10;
        repeat (2 * 40) @(negedge clk);
        check_duty(2, 5, H + 5, 40 - (H + 5), 40);

        // R9: sync stops, watchdog releases the bridge
        sync_half = 0;
        repeat (20 + TMO + 10) @(negedge clk);
        push_exp(9, 1); observe(int'(sync_lost));
        push_exp(9, 0); observe(int'(out_p_oe));
        push_exp(9, 0); observe(int'(out_n_oe));
        // R9: sync returns, flag clears and switching restarts
        sync_half = H / 2;
        repeat (PER) @(negedge clk);
        push_exp(9, 0); observe(int'(sync_lost));
        push_exp(9, 1); observe(int'(out_p_oe));

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule